// File: doc/BRIEF.md
# One-Shot PWM Channel Driver

This block drives a bank of LED channel enables with pulse-width modulation. It runs on its own grayscale clock. Each channel has a 10-bit luminance value. Two sets of these values are presented to the block: a first set and a second set. This lets one output channel time-share two LEDs.

A start strobe opens exactly one modulation window of 1024 grayscale clocks. The strobe chooses which of the two value sets drives the outputs. When the window ends, every output stays dark until another start is accepted. A halt strobe ends the window early.

Every command takes effect a fixed two clocks after it is sampled. A start that would land inside a running window is dropped. There is one exception: a start that lands on the final count of a window is taken, which chains two windows with no gap.

The strobes come from a command decoder that has already moved them into the grayscale clock domain. The value sets come from latches that belong to the surrounding serial-load logic.

Top module: `pwm_oneshot_drv`

## Requirements
- R1: While reset is asserted and after it is released, with no strobe applied, `busy` is 0 and every bit of `chan_en` is 0.
- R2: A start strobe (`start_first` or `start_second`) sampled at clock edge k opens a window at edge k+2. From that edge on, `busy` is 1 and the window count is 0.
- R3: Channel i takes its value from bits [10*i+9 : 10*i] of the selected set. During a window it is on for exactly that many clocks, from the first clock of the window, in one unbroken run.
- R4: A window lasts exactly 1024 clocks with `busy` high throughout. Afterwards `busy` and all enables stay 0 until a new start is accepted. No enable is ever high while `busy` is 0.
- R5: A value of 0 keeps its channel dark for the whole window. A value of 1023 keeps it on for 1023 of the 1024 clocks.
- R6: `start_first` takes its values from `lum_first`, and `start_second` takes its values from `lum_second`.
- R7: A start whose effect edge falls while a window is running, and not on the window's final count, is ignored. The running window keeps its set, its count and its end time.
- R8: A `halt` strobe sampled at edge k turns `busy` and every enable off at edge k+2. A start sampled one cycle after the halt is accepted as a fresh window.
- R9: When strobes coincide, `halt` wins over any start, and `start_first` wins over `start_second`.
- R10: The set chosen at window start is held for the whole window. Changes on the other value input do not reach the outputs.
- R11: A start whose effect edge is the final count of a running window is accepted. The new window follows with no idle clock in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Grayscale clock |
| rst | input | 1 | Synchronous active-high reset |
| start_first | input | 1 | One-cycle strobe: start a window using the first value set |
| start_second | input | 1 | One-cycle strobe: start a window using the second value set |
| halt | input | 1 | One-cycle strobe: force all enables off |
| lum_first | input | CHANNELS*GRAY_W | First value set, channel i at bits [GRAY_W*i +: GRAY_W] |
| lum_second | input | CHANNELS*GRAY_W | Second value set, same layout |
| chan_en | output | CHANNELS | Per-channel PWM enable |
| busy | output | 1 | High while a window runs |

## Verification
Two actions can reach the window controller on the same edge: a halt together with a start, or a start together with the natural end of a window.

The bench raises `halt` and `start_first` in the same cycle and checks that no window opens. It also places a start strobe so that its effect edge is exactly the final count of a running window. In that case `busy` must stay high across the boundary, and the next sample must already show the other value set.

A start placed one clock earlier, on the second-to-last count, must instead be dropped. The window must then end at its normal time.

// File: rtl/pwm_oneshot_pkg.sv
package pwm_oneshot_pkg;

    // Clocks between a strobe being sampled and its effect on the window
    localparam int CMD_DELAY = 2;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_FIRST  = 2'd1,
        ACT_SECOND = 2'd2,
        ACT_HALT   = 2'd3
    } act_e;

    typedef struct packed {
        logic run;
        logic use_second;
    } win_t;

    // Halt beats any start; the first set beats the second
    function automatic act_e pick_action(input logic f, input logic s, input logic h);
        act_e a;
        if (h)      a = ACT_HALT;
        else if (f) a = ACT_FIRST;
        else if (s) a = ACT_SECOND;
        else        a = ACT_NONE;
        return a;
    endfunction

    function automatic logic is_emit(input act_e a);
        return (a == ACT_FIRST) || (a == ACT_SECOND);
    endfunction

endpackage

// File: rtl/pwm_cmd_pipe.sv
module pwm_cmd_pipe
    import pwm_oneshot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_first,
    input  logic start_second,
    input  logic halt,
    output act_e act_due
);

    act_e stage_q [CMD_DELAY];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < CMD_DELAY; j++) stage_q[j] <= ACT_NONE;
        end else begin
            stage_q[0] <= pick_action(start_first, start_second, halt);
            for (int j = 1; j < CMD_DELAY; j++) stage_q[j] <= stage_q[j-1];
        end
    end

    assign act_due = stage_q[CMD_DELAY-1];

endmodule

// File: rtl/pwm_win_ctrl.sv
module pwm_win_ctrl
    import pwm_oneshot_pkg::*;
#(
    parameter int GRAY_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  act_e              act_due,
    output win_t              win,
    output logic [GRAY_W-1:0] cnt
);

    localparam logic [GRAY_W-1:0] CNT_MAX = {GRAY_W{1'b1}};

    win_t              win_q;
    logic [GRAY_W-1:0] cnt_q;
    logic              on_last;
    logic              accept;

    assign on_last = win_q.run && (cnt_q == CNT_MAX);
    assign accept  = is_emit(act_due) && (!win_q.run || on_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
            cnt_q <= '0;
        end else if (act_due == ACT_HALT) begin
            win_q.run <= 1'b0;
            cnt_q     <= '0;
        end else if (accept) begin
            win_q.run        <= 1'b1;
            win_q.use_second <= (act_due == ACT_SECOND);
            cnt_q            <= '0;
        end else if (win_q.run) begin
            if (on_last) begin
                win_q.run <= 1'b0;
                cnt_q     <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign win = win_q;
    assign cnt = cnt_q;

    // R4
    wrap_end_chk: assert property (@(posedge clk) disable iff (rst)
        (win_q.run && cnt_q == CNT_MAX && act_due == ACT_NONE) |=> !win_q.run);

    // R8
    halt_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (act_due == ACT_HALT) |=> (!win_q.run && cnt_q == '0));

    // R7
    no_retrigger_chk: assert property (@(posedge clk) disable iff (rst)
        (win_q.run && cnt_q != CNT_MAX && is_emit(act_due))
        |=> (win_q.run && win_q.use_second == $past(win_q.use_second)
             && cnt_q == $past(cnt_q) + 1'b1));

    // R11
    chain_start_chk: assert property (@(posedge clk) disable iff (rst)
        (win_q.run && cnt_q == CNT_MAX && is_emit(act_due))
        |=> (win_q.run && cnt_q == '0));

endmodule

// File: rtl/pwm_chan_cmp.sv
module pwm_chan_cmp
    import pwm_oneshot_pkg::*;
#(
    parameter int CHANNELS = 16,
    parameter int GRAY_W   = 10
) (
    input  win_t                       win,
    input  logic [GRAY_W-1:0]          cnt,
    input  logic [CHANNELS*GRAY_W-1:0] lum_first,
    input  logic [CHANNELS*GRAY_W-1:0] lum_second,
    output logic [CHANNELS-1:0]        chan_en
);

    for (genvar i = 0; i < CHANNELS; i++) begin : g_chan
        logic [GRAY_W-1:0] level;
        assign level      = win.use_second ? lum_second[i*GRAY_W +: GRAY_W]
                                           : lum_first[i*GRAY_W +: GRAY_W];
        assign chan_en[i] = win.run && (cnt < level);
    end

endmodule

// File: rtl/pwm_oneshot_drv.sv
module pwm_oneshot_drv
    import pwm_oneshot_pkg::*;
#(
    parameter int CHANNELS = 16,
    parameter int GRAY_W   = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start_first,
    input  logic                       start_second,
    input  logic                       halt,
    input  logic [CHANNELS*GRAY_W-1:0] lum_first,
    input  logic [CHANNELS*GRAY_W-1:0] lum_second,
    output logic [CHANNELS-1:0]        chan_en,
    output logic                       busy
);

    act_e              act_due;
    win_t              win;
    logic [GRAY_W-1:0] cnt;

    pwm_cmd_pipe u_pipe (
        .clk          (clk),
        .rst          (rst),
        .start_first  (start_first),
        .start_second (start_second),
        .halt         (halt),
        .act_due      (act_due)
    );

    pwm_win_ctrl #(.GRAY_W(GRAY_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .act_due (act_due),
        .win     (win),
        .cnt     (cnt)
    );

    pwm_chan_cmp #(.CHANNELS(CHANNELS), .GRAY_W(GRAY_W)) u_cmp (
        .win        (win),
        .cnt        (cnt),
        .lum_first  (lum_first),
        .lum_second (lum_second),
        .chan_en    (chan_en)
    );

    assign busy = win.run;

    // R2
    start_latency_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (($past(start_first, 3) || $past(start_second, 3)) && !$past(halt, 3)));

    // R4
    dark_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (|chan_en) |-> busy);

endmodule

// File: tb/pwm_oneshot_drv_bench.sv
module pwm_oneshot_drv_bench;

    localparam int CH   = 16;
    localparam int GW   = 10;
    localparam int SPAN = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ef = 1'b0, es = 1'b0, hl = 1'b0;
    logic [CH*GW-1:0] lum_a, lum_b;
    logic [CH-1:0]    en;
    logic             busy;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pwm_oneshot_drv u_pwm_oneshot_drv (
        .clk          (clk),
        .rst          (rst),
        .start_first  (ef),
        .start_second (es),
        .halt         (hl),
        .lum_first    (lum_a),
        .lum_second   (lum_b),
        .chan_en      (en),
        .busy         (busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lum_of(input logic [CH*GW-1:0] b, input int i);
        return int'(b[i*GW +: GW]);
    endfunction

    function automatic logic [CH-1:0] exp_mask(input logic [CH*GW-1:0] b, input int s);
        logic [CH-1:0] m;
        for (int i = 0; i < CH; i++) m[i] = (s < lum_of(b, i));
        return m;
    endfunction

    // Called at a falling edge; returns one falling edge later
    task automatic strobe(input logic f, input logic s, input logic h);
        ef = f; es = s; hl = h;
        @(negedge clk);
        ef = 1'b0; es = 1'b0; hl = 1'b0;
    endtask

    // Start a window; returns at its first sample (count 0)
    task automatic open_window(input logic f, input logic s);
        strobe(f, s, 1'b0);
        @(negedge clk);
        @(negedge clk);
    endtask

    // Samples one whole window from count 0; may poke an input at sample poke_at
    // kind: 1 start_second, 2 start_first, 3 invert lum_b
    task automatic scan_window(input logic [CH*GW-1:0] vals, input string req,
                               input int poke_at, input int kind, input bit idle_after);
        int bad [CH];
        int ons [CH];
        int busy_bad;
        logic [CH*GW-1:0] keep_b;
        busy_bad = 0;
        keep_b   = lum_b;
        for (int i = 0; i < CH; i++) begin bad[i] = 0; ons[i] = 0; end
        for (int s = 0; s < SPAN; s++) begin
            if (busy !== 1'b1) busy_bad++;
            for (int i = 0; i < CH; i++) begin
                if (en[i] === 1'b1) ons[i]++;
                if (en[i] !== (s < lum_of(vals, i))) bad[i]++;
            end
            if (s == poke_at) begin
                if (kind == 1) es = 1'b1;
                if (kind == 2) ef = 1'b1;
                if (kind == 3) lum_b = ~lum_b;
            end
            if (s == poke_at + 1) begin
                es = 1'b0; ef = 1'b0;
            end
            @(negedge clk);
        end
        lum_b = keep_b;
        for (int i = 0; i < CH; i++)
            chk(bad[i] == 0, $sformatf("R3 R5 %s ch%0d on-cycles", req, i), ons[i], lum_of(vals, i));
        chk(busy_bad == 0, $sformatf("R4 %s busy low cycles in window", req), busy_bad, 0);
        if (idle_after) begin
            chk(busy == 1'b0 && en == '0, $sformatf("R4 %s idle after window", req),
                int'({busy, en}), 0);
            @(negedge clk);
            chk(busy == 1'b0 && en == '0, $sformatf("R4 %s stays idle", req), int'({busy, en}), 0);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && en == '0, "R1 during reset", int'({busy, en}), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && en == '0, "R1 after reset", int'({busy, en}), 0);
    endtask

    task automatic t_latency();
        strobe(1'b1, 1'b0, 1'b0);
        chk(busy == 1'b0, "R2 busy one cycle after strobe", busy, 0);
        @(negedge clk);
        chk(busy == 1'b0, "R2 busy two cycles after strobe", busy, 0);
        @(negedge clk);
        chk(busy == 1'b1, "R2 busy at window start", busy, 1);
        chk(en == exp_mask(lum_a, 0), "R2 enables at count 0", int'(en), int'(exp_mask(lum_a, 0)));
        scan_window(lum_a, "R6 first set", -1, 0, 1'b1);
    endtask

    task automatic t_second();
        open_window(1'b0, 1'b1);
        scan_window(lum_b, "R6 second set", -1, 0, 1'b1);
    endtask

    task automatic t_reject();
        open_window(1'b1, 1'b0);
        scan_window(lum_a, "R7 start_second mid window", 100, 1, 1'b1);
        open_window(1'b0, 1'b1);
        scan_window(lum_b, "R7 start_first mid window", 600, 2, 1'b1);
        open_window(1'b1, 1'b0);
        scan_window(lum_a, "R7 start on second-last count", 1020, 1, 1'b1);
    endtask

    task automatic t_hold();
        open_window(1'b1, 1'b0);
        scan_window(lum_a, "R10 other set changed", 50, 3, 1'b1);
    endtask

    task automatic t_halt();
        open_window(1'b1, 1'b0);
        repeat (200) @(negedge clk);
        strobe(1'b0, 1'b0, 1'b1);
        chk(busy == 1'b1, "R8 busy before halt lands (201)", busy, 1);
        @(negedge clk);
        chk(busy == 1'b1 && en == exp_mask(lum_a, 202), "R8 enables before halt lands (202)",
            int'(en), int'(exp_mask(lum_a, 202)));
        @(negedge clk);
        chk(busy == 1'b0 && en == '0, "R8 halted", int'({busy, en}), 0);
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && en == '0, "R8 stays halted", int'({busy, en}), 0);
        open_window(1'b1, 1'b0);
        scan_window(lum_a, "R8 start after halt", -1, 0, 1'b1);
        // halt then start in the next cycle while the window still runs
        open_window(1'b1, 1'b0);
        repeat (300) @(negedge clk);
        strobe(1'b0, 1'b0, 1'b1);
        strobe(1'b0, 1'b1, 1'b0);
        @(negedge clk);
        chk(busy == 1'b0, "R8 gap between halt and new start", busy, 0);
        @(negedge clk);
        chk(busy == 1'b1, "R8 start right after halt accepted", busy, 1);
        scan_window(lum_b, "R8 start queued behind halt", -1, 0, 1'b1);
    endtask

    task automatic t_priority();
        int seen;
        seen = 0;
        strobe(1'b1, 1'b0, 1'b1);
        for (int k = 0; k < 5; k++) begin
            if (busy !== 1'b0 || en !== '0) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R9 halt beats start", seen, 0);
        open_window(1'b1, 1'b1);
        scan_window(lum_a, "R9 first beats second", -1, 0, 1'b1);
    endtask

    task automatic t_chain();
        open_window(1'b1, 1'b0);
        scan_window(lum_a, "R11 window before chain", 1021, 1, 1'b0);
        chk(busy == 1'b1, "R11 no idle clock at boundary", busy, 1);
        scan_window(lum_b, "R11 chained window", -1, 0, 1'b1);
    endtask

    initial begin
        for (int i = 0; i < CH; i++) begin
            lum_a[i*GW +: GW] = (i == 15) ? GW'(1023) : GW'(i * 68);
            lum_b[i*GW +: GW] = (i == 15) ? GW'(0)    : GW'(1023 - i * 61);
        end
        @(negedge clk);
        t_reset();
        t_latency();
        t_second();
        t_reject();
        t_hold();
        t_halt();
        t_priority();
        t_chain();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule